// File: doc/BRIEF.md
# Packed-Slot Instruction Fetch Sequencer

This block reads 32-bit program words from a synchronous memory with one cycle of read latency and hands their contents to an external execute unit. Each word has a 2-bit mode field in its top bits. Depending on that field, the block takes one of four actions. It can push the word as a literal. It can jump to an address embedded in the word. It can call that address, in which case it first hands a return address to an external return stack. Or it can run the word as a micro-loop word: it issues six 5-bit opcodes one per accepted cycle and then repeats them from its own word register as many times as a count says.

The execute unit paces the sequencer through a single ready input. An opcode or a literal stays on the outputs until the execute unit accepts it. A micro-loop word is re-run without touching memory, so a short loop body costs a single fetch however many times it repeats.

Top module: `slot_fetch_seq`

## Requirements
- R1: While rstN is low, opValid, litValid and retPush are 0 and memAddr is 0. The first cycle after reset is released asserts memRd with memAddr equal to 0.
- R2: A word whose bits [31:30] are 2'b10 issues its six 5-bit fields on opCode in this order: bits [29:25], [24:20], [19:15], [14:10], [9:5], [4:0]. Each field is issued with opValid high and is consumed in a cycle where exReady is 1. In any cycle, at most one of memRd, opValid, litValid and retPush is high.
- R3: While opValid or litValid is high and exReady is low, the strobe stays high and opCode or litData does not change.
- R4: A word with mode 2'b00 raises litValid with litData equal to bits [29:0] zero-extended to 32 bits. Once the literal is accepted, the next fetch is at the following address.
- R5: A word with mode 2'b01 issues no opcode and no literal. The next fetch is at the address in bits [15:0]. Bits [29:16] are ignored.
- R6: A word with mode 2'b11 raises retPush for exactly one cycle, with retAddr equal to the call word's address plus one. The next fetch is at the address in bits [15:0].
- R7: A mode 2'b10 word loaded with a count N of 2 or more issues its six fields N times in a row, with no memRd in between. It then fetches the next sequential word.
- R8: A mode 2'b10 word loaded with a count of 0 or 1 issues its six fields exactly once and then fetches the next sequential word.
- R9: Each word costs one memRd cycle. memData and loopCount are taken in the cycle after memRd, and that cycle has no strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memRd | output | 1 | Memory read request for address memAddr |
| memAddr | output | 16 | Program counter, used as the read address |
| memData | input | 32 | Read word, valid one cycle after memRd |
| loopCount | input | 16 | Repeat count, taken together with memData |
| opValid | output | 1 | opCode holds an opcode for the execute unit |
| opCode | output | 5 | Current slot opcode |
| exReady | input | 1 | Execute unit accepts the offered opcode or literal |
| litValid | output | 1 | litData holds a literal to push |
| litData | output | 32 | Zero-extended literal value |
| retPush | output | 1 | One-cycle strobe to push retAddr onto the return stack |
| retAddr | output | 16 | Return address (program counter plus one) |

## Verification
The bench runs one program that contains loop words with counts of 2, 0 and 1. A design that treats a count of 0 as 65536 loops, or runs a count of 1 twice, produces an extra run of opcodes that does not match the expected event list. The jump and call words carry nonzero bits above the 16-bit target, which catches a target taken from the wrong field, and the return address must be the call word's address plus one and not the target. A pseudo-random ready pattern stalls opcodes and literals at arbitrary points, and one slot is held stalled for several cycles; a design that advances the slot, or refetches while looping, changes the event order or the fetch count.

// File: rtl/slot_fetch_pkg.sv
package slot_fetch_pkg;
  localparam int WORD_W  = 32;
  localparam int SLOT_W  = 5;
  localparam int N_SLOTS = 6;
  localparam int MODE_W  = 2;
  localparam int LIT_W   = WORD_W - MODE_W;
  localparam int IDX_W   = $clog2(N_SLOTS);

  typedef enum logic [MODE_W-1:0] {
    MD_LIT  = 2'b00,
    MD_JMP  = 2'b01,
    MD_LOOP = 2'b10,
    MD_CALL = 2'b11
  } wordMode_e;

  typedef struct packed {
    logic loadWord;
    logic pcInc;
    logic pcJump;
    logic slotClr;
    logic slotInc;
    logic cntDec;
  } dpCtl_t;
endpackage

// File: rtl/slot_fetch_dp.sv
module slot_fetch_dp
  import slot_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] memData,
  input  logic [CNT_W-1:0]  loopCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] retAddr,
  output logic [SLOT_W-1:0] opCode,
  output logic [WORD_W-1:0] litData,
  output wordMode_e         wordMode,
  output logic              slotLast,
  output logic              cntMore
);
  localparam logic [IDX_W-1:0] SLOT_LAST = IDX_W'(N_SLOTS - 1);

  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] wordReg;
  logic [IDX_W-1:0]  slotIdx;
  logic [CNT_W-1:0]  loopCnt;
  logic [SLOT_W-1:0] slotField [N_SLOTS];

  // slot 0 sits just below the mode field, later slots descend
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign slotField[g] = wordReg[LIT_W - SLOT_W*(g+1) +: SLOT_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      wordReg <= '0;
      slotIdx <= '0;
      loopCnt <= '0;
    end else begin
      if (ctl.loadWord) begin
        wordReg <= memData;
        loopCnt <= loopCount;
      end
      if (ctl.slotClr)      slotIdx <= '0;
      else if (ctl.slotInc) slotIdx <= slotIdx + 1'b1;
      if (ctl.cntDec)       loopCnt <= loopCnt - 1'b1;
      if (ctl.pcJump)       pc <= wordReg[ADDR_W-1:0];
      else if (ctl.pcInc)   pc <= pc + 1'b1;
    end
  end

  assign memAddr  = pc;
  assign retAddr  = pc + 1'b1;
  assign opCode   = slotField[slotIdx];
  assign litData  = {{MODE_W{1'b0}}, wordReg[LIT_W-1:0]};
  assign wordMode = wordMode_e'(wordReg[WORD_W-1 -: MODE_W]);
  assign slotLast = (slotIdx == SLOT_LAST);
  assign cntMore  = (loopCnt > CNT_W'(1));
endmodule

// File: rtl/slot_fetch_ctrl.sv
module slot_fetch_ctrl
  import slot_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  wordMode_e fetchMode,
  input  wordMode_e wordMode,
  input  logic      slotLast,
  input  logic      cntMore,
  input  logic      exReady,
  output dpCtl_t    ctl,
  output logic      memRd,
  output logic      opValid,
  output logic      litValid,
  output logic      retPush
);
  typedef enum logic [2:0] {ST_REQ, ST_LOAD, ST_LIT, ST_BRANCH, ST_ISSUE} state_e;
  state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_REQ;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    memRd    = 1'b0;
    opValid  = 1'b0;
    litValid = 1'b0;
    retPush  = 1'b0;
    unique case (state)
      ST_REQ: begin
        memRd    = 1'b1;
        stateNxt = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.loadWord = 1'b1;
        ctl.slotClr  = 1'b1;
        case (fetchMode)
          MD_LIT:  stateNxt = ST_LIT;
          MD_LOOP: stateNxt = ST_ISSUE;
          default: stateNxt = ST_BRANCH;
        endcase
      end
      ST_LIT: begin
        litValid = 1'b1;
        if (exReady) begin
          ctl.pcInc = 1'b1;
          stateNxt  = ST_REQ;
        end
      end
      ST_BRANCH: begin
        retPush    = (wordMode == MD_CALL);
        ctl.pcJump = 1'b1;
        stateNxt   = ST_REQ;
      end
      ST_ISSUE: begin
        opValid = 1'b1;
        if (exReady) begin
          if (!slotLast) begin
            ctl.slotInc = 1'b1;
          end else if (cntMore) begin
            ctl.cntDec  = 1'b1;
            ctl.slotClr = 1'b1;
          end else begin
            ctl.pcInc = 1'b1;
            stateNxt  = ST_REQ;
          end
        end
      end
      default: stateNxt = ST_REQ;
    endcase
  end
endmodule

// File: rtl/slot_fetch_seq.sv
module slot_fetch_seq
  import slot_fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memData,
  input  logic [CNT_W-1:0]  loopCount,
  output logic              opValid,
  output logic [SLOT_W-1:0] opCode,
  input  logic              exReady,
  output logic              litValid,
  output logic [WORD_W-1:0] litData,
  output logic              retPush,
  output logic [ADDR_W-1:0] retAddr
);
  dpCtl_t    ctl;
  wordMode_e wordMode;
  wordMode_e fetchMode;
  logic      slotLast;
  logic      cntMore;

  assign fetchMode = wordMode_e'(memData[WORD_W-1 -: MODE_W]);

  slot_fetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchMode(fetchMode), .wordMode(wordMode),
    .slotLast(slotLast), .cntMore(cntMore), .exReady(exReady), .ctl(ctl),
    .memRd(memRd), .opValid(opValid), .litValid(litValid), .retPush(retPush)
  );

  slot_fetch_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memData(memData), .loopCount(loopCount),
    .memAddr(memAddr), .retAddr(retAddr), .opCode(opCode), .litData(litData),
    .wordMode(wordMode), .slotLast(slotLast), .cntMore(cntMore)
  );
endmodule

// File: rtl/slot_fetch_chk.sv
module slot_fetch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRd,
  input logic              opValid,
  input logic [4:0]        opCode,
  input logic              exReady,
  input logic              litValid,
  input logic [31:0]       litData,
  input logic              retPush,
  input logic [ADDR_W-1:0] memAddr
);
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, opValid, litValid, retPush}));

  p_op_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !exReady) |=> (opValid && $stable(opCode)));

  p_lit_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (litValid && !exReady) |=> (litValid && $stable(litData)));

  p_lit_then_fetch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (litValid && exReady) |=> (memRd && memAddr == $past(memAddr) + 1'b1));

  p_ret_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    retPush |=> (memRd && !retPush));

  p_load_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !(memRd || opValid || litValid || retPush));
endmodule

bind slot_fetch_seq slot_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .opValid(opValid), .opCode(opCode),
  .exReady(exReady), .litValid(litValid), .litData(litData),
  .retPush(retPush), .memAddr(memAddr)
);

// File: tb/test_slot_fetch_seq.sv
module test_slot_fetch_seq;
  localparam int N_EXP = 27;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [31:0] memData = '0;
  logic [15:0] loopCount = '0;
  logic        opValid;
  logic [4:0]  opCode;
  logic        exReady = 1'b0;
  logic        litValid;
  logic [31:0] litData;
  logic        retPush;
  logic [15:0] retAddr;

  int checks = 0, fails = 0;
  int evIdx = 0, fetchCnt = 0, fetchAtEnd = -1, retCnt = 0;
  int stallViol = 0, stallSeen = 0;
  logic [15:0] lastFetch = '0;
  logic        holdPrev = 1'b0;
  logic [4:0]  prevOp = '0;
  bit          recOn = 1'b1;
  bit          forceLow = 1'b0;
  logic [7:0]  lfsr = 8'hA5;

  always #10 clk = ~clk;

  slot_fetch_seq i_slot_fetch_seq (
    .clk(clk), .rstN(rstN), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .loopCount(loopCount), .opValid(opValid), .opCode(opCode), .exReady(exReady),
    .litValid(litValid), .litData(litData), .retPush(retPush), .retAddr(retAddr)
  );

  // event: {kind, value}; kind 0 = opcode, 1 = literal, 2 = return push
  localparam logic [33:0] EXP [N_EXP] = '{
    {2'd0,32'd1},  {2'd0,32'd2},  {2'd0,32'd3},  {2'd0,32'd4},  {2'd0,32'd5},  {2'd0,32'd6},
    {2'd0,32'd1},  {2'd0,32'd2},  {2'd0,32'd3},  {2'd0,32'd4},  {2'd0,32'd5},  {2'd0,32'd6},
    {2'd1,32'h01234567}, {2'd2,32'd3},
    {2'd0,32'd7},  {2'd0,32'd8},  {2'd0,32'd9},  {2'd0,32'd10}, {2'd0,32'd11}, {2'd0,32'd12},
    {2'd0,32'd13}, {2'd0,32'd14}, {2'd0,32'd15}, {2'd0,32'd16}, {2'd0,32'd17}, {2'd0,32'd18},
    {2'd1,32'h3FFFFFFF}
  };

  function automatic logic [31:0] loopWord(input int first);
    logic [31:0] w;
    w = {2'b10, 30'd0};
    for (int s = 0; s < 6; s++) w[25 - 5*s +: 5] = 5'(first + s);
    return w;
  endfunction

  function automatic logic [31:0] progWord(input logic [15:0] a);
    case (a)
      16'd0:   return loopWord(1);
      16'd1:   return {2'b00, 30'h01234567};
      16'd2:   return {2'b11, 14'h2AAA, 16'd8};
      16'd8:   return loopWord(7);
      16'd9:   return {2'b01, 14'h1555, 16'd12};
      16'd12:  return loopWord(13);
      16'd13:  return {2'b00, 30'h3FFFFFFF};
      16'd14:  return {2'b01, 14'd0, 16'd14};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [15:0] progCount(input logic [15:0] a);
    case (a)
      16'd0:   return 16'd2;
      16'd8:   return 16'd0;
      16'd12:  return 16'd1;
      default: return 16'd5;
    endcase
  endfunction

  function automatic string reqOf(input int i);
    if (i < 6)  return "R2";
    if (i < 12) return "R7";
    if (i == 12) return "R4";
    if (i == 13) return "R6";
    if (i < 20) return "R8";
    if (i < 26) return "R5";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic record(input logic [1:0] k, input logic [31:0] v);
    if (evIdx < N_EXP) begin
      check({k, v} == EXP[evIdx], reqOf(evIdx), {k, v}, EXP[evIdx]);
      evIdx++;
      if (evIdx == N_EXP) fetchAtEnd = fetchCnt;
    end else begin
      check(1'b0, "R5", {k, v}, 34'd0);
    end
  endtask

  // memory model: one cycle read latency
  initial begin
    logic        pend;
    logic [15:0] addr;
    forever begin
      @(negedge clk);
      pend = memRd;
      addr = memAddr;
      @(posedge clk);
      #1;
      if (pend) begin
        memData   = progWord(addr);
        loopCount = progCount(addr);
      end
    end
  end

  // ready driver
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      exReady = forceLow ? 1'b0 : (lfsr[0] | lfsr[1]);
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && recOn) begin
        if (memRd) begin fetchCnt++; lastFetch = memAddr; end
        if (holdPrev && !(opValid && opCode == prevOp)) stallViol++;
        holdPrev = opValid && !exReady;
        prevOp   = opCode;
        if (holdPrev) stallSeen++;
        if (opValid && exReady)  record(2'd0, {27'd0, opCode});
        if (litValid && exReady) record(2'd1, litData);
        if (retPush) begin retCnt++; record(2'd2, {16'd0, retAddr}); end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired at event %0d", evIdx);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!opValid && !litValid && !retPush, "R1", {31'd0, opValid, litValid, retPush}, 34'd0);
    check(memAddr == 16'd0, "R1", {18'd0, memAddr}, 34'd0);
    @(posedge clk); #3; rstN = 1'b1;
    @(negedge clk);
    check(memRd && memAddr == 16'd0, "R1", {17'd0, memRd, memAddr}, {17'd0, 1'b1, 16'd0});

    while (evIdx < N_EXP) @(negedge clk);
    repeat (20) @(negedge clk);
    check(fetchAtEnd == 7, "R9", 34'(fetchAtEnd), 34'd7);
    check(lastFetch == 16'd14, "R5", {18'd0, lastFetch}, 34'd14);
    check(retCnt == 1, "R6", 34'(retCnt), 34'd1);
    check(stallViol == 0, "R3", 34'(stallViol), 34'd0);
    check(stallSeen > 0, "R3", 34'(stallSeen), 34'd1);

    // directed: reset mid-run, then a long stall on the first slot
    recOn = 1'b0;
    forceLow = 1'b1;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(!opValid && !litValid && !retPush && memAddr == 16'd0, "R1",
          {15'd0, opValid, litValid, retPush, memAddr}, 34'd0);
    @(posedge clk); #3; rstN = 1'b1;
    while (!opValid) @(negedge clk);
    repeat (5) @(negedge clk);
    check(opValid && opCode == 5'd1, "R3", {28'd0, opValid, opCode}, {28'd0, 1'b1, 5'd1});
    check(!memRd, "R7", {33'd0, memRd}, 34'd0);
    forceLow = 1'b0;
    while (opValid && opCode == 5'd1) @(negedge clk);
    check(opValid && opCode == 5'd2, "R2", {28'd0, opValid, opCode}, {28'd0, 1'b1, 5'd2});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule